// File: doc/BRIEF.md
# Response busy watcher with timeout

This block follows the card's DAT0 line after a command whose response announces a busy period. When the response-end strobe arrives, it samples a synchronized copy of DAT0 and decides whether the card is holding the line busy. A low level means busy and a high level means released. If the line is already high, the block reports the release at once through a dedicated sticky flag. If the line is low, a live busy bit rises and a down-counter is loaded from the programmed maximum busy time.

While busy persists, the counter decrements once per card-clock enable pulse. The busy period ends in exactly one of two ways. If DAT0 rises first, a busy-end flag is set. If the timeout is enabled and the count runs out first, a timeout flag is set instead. Software loads the limit before it issues the command, then watches the live bit and the flags. Each flag stays set until it is written with a one.

Top module: `busyw_top`

## Requirements
- R1: After reset, `busy_now`, `idle_rel_flag`, `busy_end_flag` and `timeout_flag` are all 0.
- R2: DAT0 passes through two synchronizer flops. When `resp_end` is high and the synchronized DAT0 is low (busy), `busy_now` is 1 from the next cycle on.
- R3: When `resp_end` is high and the synchronized DAT0 is high, `idle_rel_flag` is set on the next cycle. In that case `busy_now`, `busy_end_flag` and `timeout_flag` stay 0.
- R4: While busy with `tmo_en`=1 and DAT0 low, the (L+1)-th `card_ce` pulse after the response end sets `timeout_flag` and clears `busy_now`, where L is `busy_limit`. With `tmo_en`=0 no timeout ever occurs and the counter holds at zero.
- R5: While busy, a high synchronized DAT0 clears `busy_now` and sets `busy_end_flag`, whatever the state of `card_ce`. The count stops there.
- R6: For a single busy period, at most one of `busy_end_flag` and `timeout_flag` is set. If the release and the expiry fall in the same cycle, the release wins.
- R7: `flag_clr` is write-one-to-clear: bit 0 clears `idle_rel_flag`, bit 1 clears `busy_end_flag`, bit 2 clears `timeout_flag`. Other flags are untouched. A set in the same cycle wins over a clear.
- R8: Changes of DAT0 without `resp_end` while not busy leave `busy_now` and all flags unchanged.
- R9: A `resp_end` that arrives while busy, with DAT0 still low, reloads the counter from `busy_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_ce | input | 1 | Card-clock enable, one pulse per card clock period |
| resp_end | input | 1 | Single-cycle response-end strobe |
| dat0_in | input | 1 | Asynchronous DAT0 level, low means busy |
| busy_limit | input | TW | Maximum busy time in card clock periods |
| tmo_en | input | 1 | Timeout enable |
| flag_clr | input | 3 | Write-one-to-clear pulses for the three flags |
| busy_now | output | 1 | Live busy status |
| idle_rel_flag | output | 1 | Sticky: released already at response end |
| busy_end_flag | output | 1 | Sticky: busy released later |
| timeout_flag | output | 1 | Sticky: busy outlasted the limit |

## Verification
The assertions assume that `resp_end` is a single-cycle pulse. They also assume that `busy_limit` and `tmo_en` stay steady throughout a busy period. The stimulus changes them only while the block is idle. DAT0 is changed only away from the clock edge and is held for several cycles. The expected timing therefore counts the two synchronizer stages. The sweep over limits, busy lengths and enable settings computes the winner of the release-versus-timeout race arithmetically from the number of enable pulses applied.

// File: rtl/busyw_pkg.sv
package busyw_pkg;
    localparam int NFLAG   = 3;
    localparam int FLG_IDL = 0;
    localparam int FLG_END = 1;
    localparam int FLG_TMO = 2;

    typedef struct packed {
        logic busy;
    } ctl_state_t;
endpackage

// File: rtl/busyw_sync.sv
module busyw_sync #(
    parameter int   STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb s_d.chain = d_in;
        end else begin : g_many
            always_comb s_d.chain = {s_q.chain[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.chain <= {STAGES{RST_VAL}};
        else        s_q <= s_d;
    end

    assign d_out = s_q.chain[STAGES-1];
endmodule

// File: rtl/busyw_timer.sv
module busyw_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load)
            t_d.cnt = load_val;
        else if (dec && (t_q.cnt != '0))
            t_d.cnt = t_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign zero = (t_q.cnt == '0);

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (t_q.cnt == $past(load_val))); // R9
endmodule

// File: rtl/busyw_flags.sv
module busyw_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    typedef struct packed {
        logic [N-1:0] f;
    } flg_t;

    flg_t f_d, f_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_comb f_d.f[i] = set[i] | (f_q.f[i] & ~clr[i]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag = f_q.f;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !flag[i]); // R7
            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !clr[i]) |=> flag[i]); // R7
        end
    endgenerate
endmodule

// File: rtl/busyw_top.sv
module busyw_top
    import busyw_pkg::*;
#(
    parameter int TW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_ce,
    input  logic          resp_end,
    input  logic          dat0_in,
    input  logic [TW-1:0] busy_limit,
    input  logic          tmo_en,
    input  logic [2:0]    flag_clr,
    output logic          busy_now,
    output logic          idle_rel_flag,
    output logic          busy_end_flag,
    output logic          timeout_flag
);
    logic             dat0_s;
    logic             cnt_zero;
    logic             tmr_load;
    logic             tmr_dec;
    logic             go_release;
    logic             go_timeout;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flags;
    ctl_state_t       c_d, c_q;

    busyw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (dat0_in),
        .d_out (dat0_s)
    );

    always_comb begin
        c_d        = c_q;
        flag_set   = '0;
        tmr_load   = 1'b0;
        tmr_dec    = 1'b0;
        go_release = c_q.busy && dat0_s;
        go_timeout = c_q.busy && !dat0_s && card_ce && tmo_en && cnt_zero
                     && !resp_end;
        if (resp_end && !dat0_s) begin
            c_d.busy = 1'b1;
            tmr_load = 1'b1;
        end else if (resp_end && dat0_s && !c_q.busy) begin
            flag_set[FLG_IDL] = 1'b1;
        end else if (go_release) begin
            c_d.busy          = 1'b0;
            flag_set[FLG_END] = 1'b1;
        end else if (go_timeout) begin
            c_d.busy          = 1'b0;
            flag_set[FLG_TMO] = 1'b1;
        end else if (c_q.busy && card_ce) begin
            tmr_dec = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    busyw_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (busy_limit),
        .dec      (tmr_dec),
        .zero     (cnt_zero)
    );

    busyw_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flag  (flags)
    );

    assign busy_now      = c_q.busy;
    assign idle_rel_flag = flags[FLG_IDL];
    assign busy_end_flag = flags[FLG_END];
    assign timeout_flag  = flags[FLG_TMO];

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_end && !dat0_s) |=> busy_now); // R2
    AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_end && dat0_s && !busy_now) |=> (!busy_now && idle_rel_flag)); // R3
    AST_TMO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> ($past(tmo_en) && $past(busy_now))); // R4
    AST_END_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_end_flag) |-> ($past(busy_now) && !busy_now)); // R5
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(busy_end_flag) && $rose(timeout_flag))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_now && !resp_end) |=> !busy_now); // R8
endmodule

// File: tb/busyw_top_tb.sv
module busyw_top_tb;
    localparam int CLK_PER = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          card_ce = 1'b0;
    logic          resp_end = 1'b0;
    logic          dat0_in = 1'b1;
    logic [TW-1:0] busy_limit = '0;
    logic          tmo_en = 1'b0;
    logic [2:0]    flag_clr = '0;
    logic          busy_now, idle_rel_flag, busy_end_flag, timeout_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    busyw_top #(.TW(TW), .SYNC_STAGES(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_ce       (card_ce),
        .resp_end      (resp_end),
        .dat0_in       (dat0_in),
        .busy_limit    (busy_limit),
        .tmo_en        (tmo_en),
        .flag_clr      (flag_clr),
        .busy_now      (busy_now),
        .idle_rel_flag (idle_rel_flag),
        .busy_end_flag (busy_end_flag),
        .timeout_flag  (timeout_flag)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {busy,idle,end,tmo} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {busy_now, idle_rel_flag, busy_end_flag, timeout_flag};
    endfunction

    task automatic clear_all();
        flag_clr = 3'b111; step(); flag_clr = '0;
    endtask

    task automatic set_dat0(input logic v);
        dat0_in = v; step(); step(); step();
    endtask

    task automatic pulse_resp();
        resp_end = 1'b1; step(); resp_end = 1'b0;
    endtask

    task automatic ce_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            card_ce = 1'b1; step(); card_ce = 1'b0; step();
        end
    endtask

    initial begin
        #(CLK_PER*100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 reset", outs(), 4'b0000);
        rst_n = 1'b1; step();
        chk("R1 after release", outs(), 4'b0000);

        // R8: DAT0 wiggles with no response end
        set_dat0(1'b0); ce_pulses(3); set_dat0(1'b1);
        chk("R8 no resp_end", outs(), 4'b0000);

        // R3: released already at response end
        pulse_resp();
        chk("R3 immediate release", outs(), 4'b0100);
        // R7: clear only bit 0
        flag_clr = 3'b110; step(); flag_clr = '0;
        chk("R7 other clears keep idle flag", outs(), 4'b0100);
        flag_clr = 3'b001; step(); flag_clr = '0;
        chk("R7 clear idle flag", outs(), 4'b0000);

        // R4 R5 R6 sweep
        for (int en = 0; en < 2; en++) begin
            for (int lim = 0; lim < 5; lim++) begin
                for (int d = 0; d < 7; d++) begin
                    logic want_tmo;
                    tmo_en = en[0];
                    busy_limit = TW'(lim);
                    set_dat0(1'b0);
                    pulse_resp();
                    chk("R2 busy at resp_end", outs(), 4'b1000);
                    ce_pulses(d);
                    want_tmo = (en == 1) && (d >= lim + 1);
                    chk(want_tmo ? "R4 timeout" : "R4 no timeout yet",
                        outs(), want_tmo ? 4'b0001 : 4'b1000);
                    set_dat0(1'b1); step();
                    chk(want_tmo ? "R6 timeout wins" : "R5 busy end",
                        outs(), want_tmo ? 4'b0001 : 4'b0010);
                    clear_all();
                end
            end
        end

        // R7: set beats clear, then clear of busy-end only
        tmo_en = 1'b0; busy_limit = 8'd2;
        set_dat0(1'b0); pulse_resp();
        dat0_in = 1'b1; step(); step();
        flag_clr = 3'b010; step(); flag_clr = '0;
        chk("R7 set beats clear", outs(), 4'b0010);
        flag_clr = 3'b010; step(); flag_clr = '0;
        chk("R7 clear busy end", outs(), 4'b0000);

        // R9: reload on second response end
        tmo_en = 1'b1; busy_limit = 8'd3;
        set_dat0(1'b0); pulse_resp();
        ce_pulses(2); pulse_resp(); ce_pulses(3);
        chk("R9 reload delays timeout", outs(), 4'b1000);
        ce_pulses(1);
        chk("R9 timeout after reload", outs(), 4'b0001);
        set_dat0(1'b1); clear_all();
        chk("R7 clear all", outs(), 4'b0000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule